// File: doc/BRIEF.md
# Bit-Serial Shift Engine

This block moves between 1 and 32 bits over a three-wire synchronous serial link, most significant bit first. It produces the serial clock and the outgoing data line, and it samples the incoming data line. A single start strobe launches a transfer. The strobe carries a direction (send or receive), a bit count, a data word and a timing value. The timing value sets the length of one timing unit in system clock cycles.

Each bit occupies four equal timing units. In the first unit the outgoing data settles while the serial clock is low. The clock is then high for two units and low again for the last unit.

- When sending, the low bits of the word that the count selects are moved to the top of the word first, so a short transfer begins with its own leading bit.
- When receiving, each sampled bit enters at bit 0 and the earlier bits move up, so the first bit received ends at the top of the count.

A busy flag covers the whole transfer. A one-cycle done pulse marks its end, and the received word is valid at that pulse.

Top module: `serial_shift_engine`

## Requirements
- R1: After reset, busy, done, the serial clock and the outgoing data line are all 0, and rx_data reads 0.
- R2: In send mode with a count N below 32, the engine sends bits N-1 down to 0 of tx_data. A count of 32 sends the whole word unchanged.
- R3: Bits leave most significant first. sdo changes only at the start of a bit, one timing unit before the serial clock rises, and never while the clock is high.
- R4: One timing unit lasts unit_ticks cycles, and a unit_ticks of 0 is taken as 1. Each bit lasts four units. The serial clock is low for the first unit, high for the second and third, and low for the fourth.
- R5: In receive mode, sdi is sampled at the system clock edge on which the serial clock rises. The first bit is therefore taken before any serial clock edge.
- R6: The first bit received ends at bit N-1 of rx_data and the last at bit 0. Bits above N-1 are 0.
- R7: busy rises on the cycle after an accepted start and stays high for exactly 4·N units. done is high for the single cycle in which busy has just fallen. rx_data is valid in that cycle and holds until the next receive transfer is accepted.
- R8: A count of 0 produces no clock pulse and leaves busy low. It raises done for one cycle on the cycle after the start.
- R9: A start while busy is high is ignored. The running transfer keeps its count, data, timing and direction.
- R10: While idle the serial clock is low and sdo keeps the last value it drove. A receive transfer leaves sdo unchanged.
- R11: A count above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, one cycle |
| rx_mode | input | 1 | 1 = receive, 0 = send |
| bit_count | input | 6 | Number of bits, 0 to 63 (clamped to 32) |
| tx_data | input | 32 | Word to send, right-aligned |
| unit_ticks | input | 16 | Timing unit length in clock cycles |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_data | output | 32 | Received word, right-aligned |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |

## Verification
The embedded properties check on every cycle the following:
- the serial clock is low whenever the engine is idle;
- sdo never moves while the clock is high;
- done is a single-cycle pulse that never coincides with busy;
- the received word holds while idle;
- a zero count goes straight to done;
- a start during busy never raises the remaining bit count;
- the tick counter stays inside its unit.

Only the bench scenarios can show the rest, using a reference that predicts every cycle of sck, sdo, busy and done. This covers the exact slot lengths for several unit values, the left-justified bit order for short, full and clamped counts, and the sampling point. The sampling point is exposed by driving the complement of each bit on sdi outside the setup unit.

// File: rtl/serial_shift_pkg.sv
package serial_shift_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  count_t;

    // four equal timing units inside one bit
    typedef enum logic [1:0] {
        SLOT_SETUP = 2'd0,
        SLOT_HI_A  = 2'd1,
        SLOT_HI_B  = 2'd2,
        SLOT_TAIL  = 2'd3
    } slot_e;

    // counts above the word width collapse to a full word
    function automatic count_t clamp_count(input count_t n);
        if (n > count_t'(WORD_W))
            return count_t'(WORD_W);
        return n;
    endfunction

    // move the low n bits to the top of the word
    function automatic word_t left_align(input word_t v, input count_t n);
        if (n >= count_t'(WORD_W))
            return v;
        return v << (count_t'(WORD_W) - n);
    endfunction

endpackage

// File: rtl/bit_slot_timer.sv
module bit_slot_timer
    import serial_shift_pkg::*;
#(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [TICK_W-1:0] unit_ticks,
    output slot_e             slot,
    output logic              slot_end
);

    logic [TICK_W-1:0] unit_q;
    logic [TICK_W-1:0] tick_q;
    slot_e             slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_q <= TICK_W'(1);
            tick_q <= '0;
            slot_q <= SLOT_SETUP;
        end else if (load) begin
            unit_q <= (unit_ticks == '0) ? TICK_W'(1) : unit_ticks;
            tick_q <= '0;
            slot_q <= SLOT_SETUP;
        end else if (run) begin
            if (tick_q == unit_q - TICK_W'(1)) begin
                tick_q <= '0;
                case (slot_q)
                    SLOT_SETUP: slot_q <= SLOT_HI_A;
                    SLOT_HI_A:  slot_q <= SLOT_HI_B;
                    SLOT_HI_B:  slot_q <= SLOT_TAIL;
                    default:    slot_q <= SLOT_SETUP;
                endcase
            end else begin
                tick_q <= tick_q + TICK_W'(1);
            end
        end
    end

    assign slot     = slot_q;
    assign slot_end = run && (tick_q == unit_q - TICK_W'(1));

    // R4: the tick counter never leaves its unit window
    p_tick_bound_r4: assert property (@(posedge clk) disable iff (rst)
        run |-> (tick_q < unit_q));

endmodule

// File: rtl/shift_word.sv
module shift_word
    import serial_shift_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_tx,
    input  logic  load_rx,
    input  word_t aligned,
    input  logic  tx_step,
    input  logic  rx_step,
    input  logic  sdi,
    output logic  sdo,
    output word_t rx_word
);

    word_t tx_q;
    word_t rx_q;
    logic  sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (load_tx) begin
                tx_q  <= aligned;
                sdo_q <= aligned[WORD_W-1];
            end else if (tx_step) begin
                tx_q  <= tx_q << 1;
                sdo_q <= tx_q[WORD_W-2];
            end
            if (load_rx)
                rx_q <= '0;
            else if (rx_step)
                rx_q <= {rx_q[WORD_W-2:0], sdi};
        end
    end

    assign sdo     = sdo_q;
    assign rx_word = rx_q;

endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
    import serial_shift_pkg::*;
#(
    parameter int TICK_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 rx_mode,
    input  logic [CNT_W-1:0]     bit_count,
    input  logic [WORD_W-1:0]    tx_data,
    input  logic [TICK_W-1:0]    unit_ticks,
    input  logic                 sdi,
    output logic                 busy,
    output logic                 done,
    output logic [WORD_W-1:0]    rx_data,
    output logic                 sck,
    output logic                 sdo
);

    logic   busy_q, done_q, sck_q, rx_q;
    count_t left_q;
    count_t n_eff;
    logic   accept, launch;
    slot_e  slot;
    logic   slot_end;
    logic   last_bit;

    assign n_eff    = clamp_count(bit_count);
    assign accept   = start && !busy_q;
    assign launch   = accept && (n_eff != '0);
    assign last_bit = (left_q == count_t'(1));

    bit_slot_timer #(.TICK_W(TICK_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load       (launch),
        .run        (busy_q),
        .unit_ticks (unit_ticks),
        .slot       (slot),
        .slot_end   (slot_end)
    );

    shift_word u_word (
        .clk     (clk),
        .rst     (rst),
        .load_tx (launch && !rx_mode),
        .load_rx (launch && rx_mode),
        .aligned (left_align(tx_data, n_eff)),
        .tx_step (busy_q && slot_end && (slot == SLOT_TAIL) && !last_bit && !rx_q),
        .rx_step (busy_q && slot_end && (slot == SLOT_SETUP) && rx_q),
        .sdi     (sdi),
        .sdo     (sdo),
        .rx_word (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sck_q  <= 1'b0;
            rx_q   <= 1'b0;
            left_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (n_eff == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    rx_q   <= rx_mode;
                    left_q <= n_eff;
                end
            end else if (busy_q && slot_end) begin
                case (slot)
                    SLOT_SETUP: sck_q <= 1'b1;
                    SLOT_HI_B:  sck_q <= 1'b0;
                    SLOT_TAIL: begin
                        if (last_bit) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                        left_q <= left_q - count_t'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign sck  = sck_q;

    // R10: clock idles low
    p_sck_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);
    // R3: data line frozen while the clock is high
    p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(sdo));
    // R7: done lasts one cycle and never overlaps busy
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R7: received word holds while idle
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(rx_data));
    // R8: zero count goes straight to done
    p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && bit_count == '0) |=> (done && !busy));
    // R9: a start during a transfer never reloads the bit counter
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (left_q <= $past(left_q)));

endmodule

// File: tb/serial_shift_engine_tb.sv
`timescale 1ns/1ps
module serial_shift_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rx_mode = 1'b0;
    logic [5:0]  bit_count = '0;
    logic [31:0] tx_data = '0;
    logic [15:0] unit_ticks = '0;
    logic        sdi = 1'b0;
    logic        busy, done, sck, sdo;
    logic [31:0] rx_data;

    always #2.5 clk = ~clk;

    serial_shift_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .rx_mode(rx_mode),
        .bit_count(bit_count), .tx_data(tx_data), .unit_ticks(unit_ticks),
        .sdi(sdi), .busy(busy), .done(done), .rx_data(rx_data),
        .sck(sck), .sdo(sdo)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit          m_active = 0;
    bit          m_done = 0;
    int          m_e = 0;
    int          m_n = 0;
    int          m_d = 1;
    bit          m_rx = 0;
    logic [31:0] m_word = '0;
    logic [31:0] m_pat = '0;
    logic        m_sdo = 1'b0;
    logic [31:0] m_rxval = '0;
    logic [31:0] rx_pat = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            int bitn, slot, per;
            logic esck, esdo;
            per  = 4 * m_d;
            bitn = m_active ? m_e / per : 0;
            slot = m_active ? (m_e % per) / m_d : 0;
            esck = m_active && (slot == 1 || slot == 2);
            esdo = (m_active && !m_rx) ? m_word[31 - bitn] : m_sdo;
            chk("R7 busy", 32'(busy), 32'(m_active));
            chk("R7/R8 done", 32'(done), 32'(m_done));
            chk("R4/R10 sck", 32'(sck), 32'(esck));
            chk("R2/R3/R10 sdo", 32'(sdo), 32'(esdo));
            if (!m_active)
                chk("R1/R5/R6/R7 rx_data", rx_data, m_rxval);
            // drive sdi: true bit only during the setup unit (R5)
            if (m_active && m_rx)
                sdi <= (slot == 0) ? m_pat[31 - bitn] : ~m_pat[31 - bitn];
            // advance the model
            m_done = 0;
            if (m_active) begin
                if (m_e + 1 == m_n * per) begin
                    m_active = 0;
                    m_done = 1;
                    if (m_rx)
                        m_rxval = (m_n == 32) ? m_pat : (m_pat >> (32 - m_n));
                    else
                        m_sdo = m_word[32 - m_n];
                end else begin
                    m_e++;
                end
            end else if (start) begin
                int n;
                n = (bit_count > 32) ? 32 : int'(bit_count);   // R11
                if (n == 0) begin
                    m_done = 1;                                  // R8
                end else begin
                    m_active = 1;
                    m_e = 0;
                    m_n = n;
                    m_d = (unit_ticks == 0) ? 1 : int'(unit_ticks);
                    m_rx = rx_mode;
                    m_pat = rx_pat;
                    m_word = (n == 32) ? tx_data : (tx_data << (32 - n));
                    if (rx_mode) m_rxval = 'x;
                end
            end
        end
    end

    task automatic kick(input bit rxm, input int n, input logic [31:0] data,
                        input int ticks, input logic [31:0] pat);
        @(posedge clk); #1;
        rx_mode = rxm; bit_count = 6'(n); tx_data = data;
        unit_ticks = 16'(ticks); rx_pat = pat; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy || done) begin
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                finished = 1;
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);           // R1 reset state checked per cycle
        kick(0, 8,  32'h0000_00A5, 2, '0);   wait_idle();  // R2 R3 R4
        kick(0, 32, 32'hC35A_0F81, 1, '0);   wait_idle();  // R2 full word
        kick(0, 1,  32'hFFFF_FFFF, 3, '0);   wait_idle();  // single bit
        kick(0, 5,  32'h0000_0012, 0, '0);   wait_idle();  // R4 zero ticks
        kick(1, 5,  '0, 2, 32'hB000_0000);   wait_idle();  // R5 R6 R10
        kick(1, 32, '0, 1, 32'h9E37_79B9);   wait_idle();  // R6 full
        kick(1, 1,  '0, 4, 32'h8000_0000);   wait_idle();
        kick(0, 0,  32'h1234_5678, 2, '0);   wait_idle();  // R8
        kick(0, 40, 32'h8001_7FFE, 1, '0);   wait_idle();  // R11
        // R9: start while busy is ignored
        kick(0, 6,  32'h0000_002D, 2, '0);
        repeat (5) @(posedge clk);
        kick(1, 3,  32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
        wait_idle();
        kick(1, 12, '0, 1, 32'h5A3C_0000);
        repeat (4) @(posedge clk);
        kick(0, 2,  32'h3, 5, '0);
        wait_idle();
        repeat (5) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule